// File: doc/BRIEF.md
# Precise Exception Tracker for a Five-Stage In-Order Pipeline

This block follows every instruction of a five-stage in-order pipeline (fetch, decode, execute, memory, write-back) with a small tag: a valid bit, two write intents (register and store), and an eight-bit vector of posted fault causes. The datapath reports faults to the block as they are found in each stage. The block does not act on a fault at that moment. It sets the matching bit in the faulting instruction's vector, and the vector then moves down the pipe with the instruction. From then on, every write enable that instruction would raise is held low.

The fault is resolved only when the instruction moves from the memory stage into write-back. At that point the block records the instruction's PC and an encoded cause, and raises a one-cycle taken pulse. It zeros every pipeline latch, including the one the faulting instruction was entering, and makes the next fetch come from a fixed handler address. An older instruction always reaches this point before a younger one. Faults are therefore taken in program order, even when a younger instruction found its fault earlier in time. A return input reloads the saved PC into fetch, squashes whatever is in flight, and clears the pending flag.

Top module: `exc_precise_pipe`

## Requirements
- R1: After reset, fetch_pc equals RESET_PC (default 0x100). wb_valid, reg_we, mem_we, exc_taken, exc_pending and exc_cause are all 0.
- R2: With no fault and no return, fetch_pc grows by PC_STEP (default 4) on every clock. The instruction fetched in cycle n is in write-back in cycle n+4, with wb_valid=1 and wb_pc equal to its fetch PC.
- R3: Vector bit positions are fixed. if_fault[0..2] go to bits 0..2, id_illegal to bit 3, ex_arith to bit 4, and mem_fault[0..2] to bits 5..7. A cause input is posted only when its stage holds a valid instruction; otherwise it has no effect.
- R4: mem_we is 1 only for a valid store in the memory stage whose vector is empty, counting the memory stage's own fault inputs in that same cycle.
- R5: reg_we is 1 only when write-back holds a valid instruction with a register write intent and an empty vector.
- R6: A fault is taken on the clock edge that would move the faulting instruction from memory into write-back. In the next cycle, exc_taken=1 and exc_pc equals that instruction's fetch PC.
- R7: exc_cause equals the index of the lowest set vector bit plus one, so the earliest stage wins. The codes are 1=fetch page fault, 2=fetch misaligned, 3=fetch protection, 4=illegal opcode, 5=arithmetic, 6=data page fault, 7=data misaligned, 8=data protection.
- R8: If instruction i and the younger instruction i+1 both post faults, only the fault of i is taken, even when i+1 posted first.
- R9: Taking a fault zeros all four pipeline latches. In the following cycle fetch_pc equals HANDLER_PC (default 0x80), and exc_taken stays high for exactly one cycle.
- R10: A pulse on eret loads exc_pc into fetch_pc on the next edge and zeros all pipeline latches. A fault taken on the same edge wins over the return.
- R11: exc_pending becomes 1 when a fault is taken and returns to 0 after eret.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| if_fault | input | 3 | Fetch-stage faults: page fault, misaligned, protection |
| id_illegal | input | 1 | Decode stage found an illegal opcode |
| id_rd_we | input | 1 | Decoded instruction writes a register |
| id_store | input | 1 | Decoded instruction writes memory |
| ex_arith | input | 1 | Execute stage arithmetic fault |
| mem_fault | input | 3 | Memory-stage faults: page fault, misaligned, protection |
| eret | input | 1 | Return from handler: resume at saved PC |
| fetch_pc | output | PC_W | Address fetched this cycle |
| wb_valid | output | 1 | Write-back stage holds a valid instruction |
| wb_pc | output | PC_W | PC of the write-back instruction |
| reg_we | output | 1 | Register write enable at write-back |
| mem_we | output | 1 | Memory write enable at the memory stage |
| exc_taken | output | 1 | One-cycle pulse: fault taken |
| exc_pc | output | PC_W | PC of the faulting instruction |
| exc_cause | output | 4 | Encoded cause of the taken fault |
| exc_pending | output | 1 | Fault taken and not yet returned from |

## Verification
A vector bit that is dropped or misplaced between stages shows up four cycles after fetch at the latest. Either the taken pulse arrives in the wrong cycle, or the cause code is wrong, or a suppressed store or register write slips through at mem_we or reg_we. A wrong squash shows up one cycle after the taken pulse: a younger instruction's fault is taken as well, or wb_valid stays high, or fetch_pc is not the handler address. The bench injects single, multiple and crossed faults at fixed distances from reset, so every expected cycle, PC and code is known in advance.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int VEC_W  = 8;
  localparam int CODE_W = 4;
  localparam int STAGES = 4;   // latches: decode, execute, memory, write-back
  localparam int B_IF   = 0;   // bits 0..2
  localparam int B_ID   = 3;
  localparam int B_EX   = 4;
  localparam int B_MEM  = 5;   // bits 5..7

  typedef struct packed {
    logic             valid;
    logic             rd_we;
    logic             st;
    logic [VEC_W-1:0] vec;
  } exc_tag_t;

  // lowest set bit wins: earliest stage first
  function automatic logic [CODE_W-1:0] first_cause(input logic [VEC_W-1:0] v);
    logic [CODE_W-1:0] c;
    c = '0;
    for (int i = VEC_W - 1; i >= 0; i--) begin
      if (v[i]) c = CODE_W'(i + 1);
    end
    return c;
  endfunction
endpackage

// File: rtl/exc_cause_enc.sv
module exc_cause_enc
  import exc_pkg::*;
(
  input  logic [VEC_W-1:0]  vec,
  output logic [CODE_W-1:0] code
);
  always_comb code = first_cause(vec);

  always_comb begin
    assert_code_zero_R7: assert ((code == '0) == (vec == '0));
  end
endmodule

// File: rtl/exc_stage_reg.sv
module exc_stage_reg
  import exc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            flush,
  input  exc_tag_t        d_tag,
  input  logic [PC_W-1:0] d_pc,
  output exc_tag_t        q_tag,
  output logic [PC_W-1:0] q_pc
);
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      q_tag <= '0;
      q_pc  <= '0;
    end else begin
      q_tag <= d_tag;
      q_pc  <= d_pc;
    end
  end

  assert_flush_clears_R9: assert property (@(posedge clk) disable iff (rst)
    flush |=> !q_tag.valid);
endmodule

// File: rtl/exc_fetch_pc.sv
module exc_fetch_pc #(
  parameter int              PC_W       = 32,
  parameter logic [PC_W-1:0] RESET_PC   = 'h100,
  parameter logic [PC_W-1:0] HANDLER_PC = 'h80,
  parameter int              PC_STEP    = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take,
  input  logic            resume,
  input  logic [PC_W-1:0] resume_pc,
  output logic [PC_W-1:0] pc
);
  localparam logic [PC_W-1:0] STEP = PC_W'(PC_STEP);

  always_ff @(posedge clk) begin
    if (rst)         pc <= RESET_PC;
    else if (take)   pc <= HANDLER_PC;
    else if (resume) pc <= resume_pc;
    else             pc <= pc + STEP;
  end

  assert_seq_fetch_R2: assert property (@(posedge clk) disable iff (rst)
    !(take || resume) |=> pc == $past(pc) + STEP);
endmodule

// File: rtl/exc_precise_pipe.sv
module exc_precise_pipe
  import exc_pkg::*;
#(
  parameter int              PC_W       = 32,
  parameter logic [PC_W-1:0] RESET_PC   = 'h100,
  parameter logic [PC_W-1:0] HANDLER_PC = 'h80,
  parameter int              PC_STEP    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        if_fault,
  input  logic              id_illegal,
  input  logic              id_rd_we,
  input  logic              id_store,
  input  logic              ex_arith,
  input  logic [2:0]        mem_fault,
  input  logic              eret,
  output logic [PC_W-1:0]   fetch_pc,
  output logic              wb_valid,
  output logic [PC_W-1:0]   wb_pc,
  output logic              reg_we,
  output logic              mem_we,
  output logic              exc_taken,
  output logic [PC_W-1:0]   exc_pc,
  output logic [CODE_W-1:0] exc_cause,
  output logic              exc_pending
);
  localparam int S_ID = 0, S_EX = 1, S_MEM = 2, S_WB = 3;

  exc_tag_t        tag_d [STAGES];
  exc_tag_t        tag_q [STAGES];
  logic [PC_W-1:0] pc_d  [STAGES];
  logic [PC_W-1:0] pc_q  [STAGES];
  logic            take;
  logic            flush;
  logic [CODE_W-1:0] code;

  // post each stage's causes into the tag it hands on
  always_comb begin
    tag_d[S_ID]                  = '0;
    tag_d[S_ID].valid            = 1'b1;
    tag_d[S_ID].vec[B_IF +: 3]   = if_fault;
    pc_d[S_ID]                   = fetch_pc;

    tag_d[S_EX]                  = tag_q[S_ID];
    tag_d[S_EX].rd_we            = tag_q[S_ID].valid & id_rd_we;
    tag_d[S_EX].st               = tag_q[S_ID].valid & id_store;
    tag_d[S_EX].vec[B_ID]        = tag_q[S_ID].vec[B_ID] | (tag_q[S_ID].valid & id_illegal);
    pc_d[S_EX]                   = pc_q[S_ID];

    tag_d[S_MEM]                 = tag_q[S_EX];
    tag_d[S_MEM].vec[B_EX]       = tag_q[S_EX].vec[B_EX] | (tag_q[S_EX].valid & ex_arith);
    pc_d[S_MEM]                  = pc_q[S_EX];

    tag_d[S_WB]                  = tag_q[S_MEM];
    tag_d[S_WB].vec[B_MEM +: 3]  = tag_q[S_MEM].vec[B_MEM +: 3]
                                 | ({3{tag_q[S_MEM].valid}} & mem_fault);
    pc_d[S_WB]                   = pc_q[S_MEM];
  end

  // resolved on the way into write-back: program order by construction
  assign take  = tag_q[S_MEM].valid && (tag_d[S_WB].vec != '0);
  assign flush = take || eret;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    exc_stage_reg #(.PC_W(PC_W)) u_stage (
      .clk  (clk),
      .rst  (rst),
      .flush(flush),
      .d_tag(tag_d[k]),
      .d_pc (pc_d[k]),
      .q_tag(tag_q[k]),
      .q_pc (pc_q[k])
    );
  end

  exc_fetch_pc #(
    .PC_W(PC_W), .RESET_PC(RESET_PC), .HANDLER_PC(HANDLER_PC), .PC_STEP(PC_STEP)
  ) u_fetch (
    .clk      (clk),
    .rst      (rst),
    .take     (take),
    .resume   (eret),
    .resume_pc(exc_pc),
    .pc       (fetch_pc)
  );

  exc_cause_enc u_enc (.vec(tag_d[S_WB].vec), .code(code));

  always_ff @(posedge clk) begin
    if (rst) begin
      exc_taken   <= 1'b0;
      exc_pc      <= '0;
      exc_cause   <= '0;
      exc_pending <= 1'b0;
    end else begin
      exc_taken <= take;
      if (take) begin
        exc_pc      <= pc_q[S_MEM];
        exc_cause   <= code;
        exc_pending <= 1'b1;
      end else if (eret) begin
        exc_pending <= 1'b0;
      end
    end
  end

  assign mem_we   = tag_q[S_MEM].valid && tag_q[S_MEM].st && (tag_d[S_WB].vec == '0);
  assign reg_we   = tag_q[S_WB].valid && tag_q[S_WB].rd_we && (tag_q[S_WB].vec == '0);
  assign wb_valid = tag_q[S_WB].valid;
  assign wb_pc    = pc_q[S_WB];

  assert_pulse_once_R9: assert property (@(posedge clk) disable iff (rst)
    exc_taken |=> !exc_taken);
  assert_handler_fetch_R9: assert property (@(posedge clk) disable iff (rst)
    exc_taken |-> (fetch_pc == HANDLER_PC) && !wb_valid);
  assert_no_store_on_fault_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(exc_taken) |-> !$past(mem_we));
  assert_reg_we_valid_R5: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> wb_valid);
  assert_wb_clean_R6: assert property (@(posedge clk) disable iff (rst)
    tag_q[S_WB].valid |-> (tag_q[S_WB].vec == '0) && !tag_q[S_WB].st || tag_q[S_WB].st);
  assert_pending_set_R11: assert property (@(posedge clk) disable iff (rst)
    exc_taken |-> exc_pending);
endmodule

// File: tb/exc_precise_pipe_tb.sv
`timescale 1ns/1ps
module exc_precise_pipe_tb;
  localparam logic [31:0] RST_PC = 32'h100;
  localparam logic [31:0] HND_PC = 32'h80;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  if_fault = '0;
  logic        id_illegal = 1'b0, id_rd_we = 1'b0, id_store = 1'b0, ex_arith = 1'b0;
  logic [2:0]  mem_fault = '0;
  logic        eret = 1'b0;
  logic [31:0] fetch_pc, wb_pc, exc_pc;
  logic        wb_valid, reg_we, mem_we, exc_taken, exc_pending;
  logic [3:0]  exc_cause;

  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  exc_precise_pipe u_dut (
    .clk(clk), .rst(rst), .if_fault(if_fault), .id_illegal(id_illegal),
    .id_rd_we(id_rd_we), .id_store(id_store), .ex_arith(ex_arith),
    .mem_fault(mem_fault), .eret(eret), .fetch_pc(fetch_pc), .wb_valid(wb_valid),
    .wb_pc(wb_pc), .reg_we(reg_we), .mem_we(mem_we), .exc_taken(exc_taken),
    .exc_pc(exc_pc), .exc_cause(exc_cause), .exc_pending(exc_pending)
  );

  // {fault vector of instruction at 0x108, fault vector of instruction at 0x10C}
  localparam logic [15:0] TBL [12] = '{
    16'h0000, 16'h0100, 16'h0600, 16'h0800, 16'h1000, 16'h2000,
    16'hC000, 16'h8000, 16'h1001, 16'h0008, 16'h9000, 16'h1800
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; if_fault = '0; id_illegal = 0; ex_arith = 0; mem_fault = '0;
    eret = 0; id_rd_we = 0; id_store = 0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  function automatic logic [7:0] vec_of(input int idx, input logic [15:0] e);
    if (idx == 2) return e[15:8];
    if (idx == 3) return e[7:0];
    return 8'h00;
  endfunction

  function automatic logic [3:0] exp_code(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return 4'(i + 1);
    return 4'd0;
  endfunction

  initial begin
    #3000000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // R1: reset state
    do_reset();
    chk(fetch_pc == RST_PC, "R1", "fetch_pc", fetch_pc, RST_PC);
    chk({wb_valid, reg_we, mem_we, exc_taken, exc_pending} == 5'b0, "R1", "flags",
        {wb_valid, reg_we, mem_we, exc_taken, exc_pending}, 0);
    chk(exc_cause == 0, "R1", "exc_cause", exc_cause, 0);

    // R2 / R5: clean stream, PC sequence and write-back timing
    id_rd_we = 1;
    for (int k = 1; k <= 4; k++) begin
      @(posedge clk); #1;
      chk(fetch_pc == RST_PC + 4 * k, "R2", "fetch_pc step", fetch_pc, RST_PC + 4 * k);
    end
    chk(wb_valid && wb_pc == RST_PC, "R2", "wb_pc after 4 cycles", wb_pc, RST_PC);
    chk(reg_we == 1'b1, "R5", "reg_we clean", reg_we, 1);

    // R3: causes on empty stages are ignored
    do_reset();
    id_rd_we = 1;
    for (int n = 0; n < 9; n++) begin
      id_illegal = (n == 0);
      ex_arith   = (n <= 1);
      mem_fault  = (n <= 2) ? 3'b111 : 3'b000;
      @(posedge clk); #1;
      chk(!exc_taken, "R3", "no fault from empty stage", exc_taken, 0);
      if (n == 3) chk(reg_we, "R3", "first instr retires", reg_we, 1);
    end

    // R4 R5 R6 R7 R8 R9: table walk
    for (int e = 0; e < 12; e++) begin
      logic [7:0] va, vb;
      int taken_cnt, exp_n;
      logic [31:0] epc;
      va = TBL[e][15:8]; vb = TBL[e][7:0];
      exp_n = (va != 0) ? 5 : 6;
      epc   = (va != 0) ? RST_PC + 8 : RST_PC + 12;
      taken_cnt = 0;
      do_reset();
      id_rd_we = 1; id_store = 1;
      for (int n = 0; n < 10; n++) begin
        if_fault   = vec_of(n, TBL[e])[2:0];
        id_illegal = vec_of(n - 1, TBL[e])[3];
        ex_arith   = vec_of(n - 2, TBL[e])[4];
        mem_fault  = vec_of(n - 3, TBL[e])[7:5];
        #1;
        if (n == 5) chk(mem_we == (va == 0), "R4", "store gate", mem_we, va == 0);
        @(posedge clk); #1;
        if (n == 5) chk(reg_we == (va == 0), "R5", "reg write gate", reg_we, va == 0);
        if (exc_taken) begin
          taken_cnt++;
          if (taken_cnt == 1) begin
            chk(n == exp_n, "R6", "taken cycle", n, exp_n);
            chk(exc_pc == epc, "R8", "exc_pc", exc_pc, epc);
            chk(exc_cause == exp_code((va != 0) ? va : vb), "R7", "cause",
                exc_cause, exp_code((va != 0) ? va : vb));
            chk(fetch_pc == HND_PC && !wb_valid, "R9", "handler fetch", fetch_pc, HND_PC);
            chk(exc_pending, "R11", "pending set", exc_pending, 1);
          end
        end
      end
      chk(taken_cnt == (((va | vb) != 0) ? 1 : 0), "R9", "pulse count",
          taken_cnt, ((va | vb) != 0) ? 1 : 0);
    end

    // R10 R11: return from handler
    do_reset();
    id_rd_we = 1;
    if_fault = 3'b001;               // instruction at 0x100 faults in fetch
    @(posedge clk); #1;
    if_fault = 3'b000;
    repeat (5) @(posedge clk);
    #1;
    chk(exc_pending && exc_pc == RST_PC, "R11", "pending before return", exc_pc, RST_PC);
    eret = 1;
    @(posedge clk); #1;
    eret = 0;
    chk(fetch_pc == RST_PC, "R10", "resume pc", fetch_pc, RST_PC);
    chk(!exc_pending, "R11", "pending cleared", exc_pending, 0);
    chk(!wb_valid, "R10", "squash on return", wb_valid, 0);
    repeat (4) @(posedge clk);
    #1;
    chk(wb_valid && wb_pc == RST_PC, "R10", "re-executed instr in WB", wb_pc, RST_PC);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule